// File: doc/BRIEF.md
# Banded Video Histogram and Remap Unit

This block watches one stream of 8-bit monochrome pixels. It counts how often each intensity occurs, keeping up to four separate histograms at the same time. A programmable table gives each video line a 2-bit region code, so one band of lines (above a horizon, for example) can collect statistics apart from another band of the same image. Each pixel is also sent through the remapping table picked for its region and leaves one cycle later. A per-region depth setting can clear the low one or two bits of the remapped value, which gives 7-bit or 6-bit output.

The counts are double buffered. While one bank counts the current frame, the other bank holds the finished previous frame, and the readout port reads that bank. An end-of-frame strobe swaps the two banks and raises a one-cycle done pulse. When clear-on-frame is on, the first pixel of a frame wipes the bank that is about to be filled. The equalization math that uses these counts runs elsewhere.

Top module: `vid_region_hist`

## Requirements
- R1: After reset, every readable count is 0, `out_valid` is 0, `frame_done` is 0, clear-on-frame is on, every depth code is 0 and every region selects table 0.
- R2: Each accepted pixel (`pix_valid`=1) adds one to the bin equal to its value in the histogram of its line's region. The addition goes into the counting bank.
- R3: The pixel that has `pix_sof` set is on line 0. Any other pixel with `pix_sol` set starts the next line. A line's region is the 2-bit code written for that line number (register select 0, address = line number, data bits [1:0]).
- R4: A count that has reached its maximum value (2^CNT_W-1) stays at that value.
- R5: `rd_count` returns the count of bin `rd_bin` of region `rd_region` from the bank that is not counting. The value does not change while pixels arrive.
- R6: `frame_end` swaps the banks after its cycle ends. A pixel in the same cycle still counts toward the frame that is ending. `frame_done` is high for exactly the one cycle after `frame_end`.
- R7: With clear-on-frame set (register select 2, address 0, data bit 0), the `pix_sof` pixel clears every bin of the counting bank and is then counted as 1. With it clear, counts add onto what that bank already holds.
- R8: `out_data` equals table[selected table of the pixel's region][pixel value], one cycle after the pixel, with `out_valid` high. Tables are written with register select 1, address = {table[1:0], index[7:0]}. Each region's table number is set with register select 2, address 2, data bits [2r+1:2r].
- R9: Each region has a depth code (register select 2, address 1, data bits [2r+1:2r]). Code 0 passes the 8-bit table output unchanged, code 1 forces bit 0 to zero, and codes 2 and 3 force bits 1:0 to zero.
- R10: A configuration write takes effect for pixels in the cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | PIX_W | Pixel intensity |
| pix_sol | input | 1 | First pixel of a line |
| pix_sof | input | 1 | First pixel of a frame |
| frame_end | input | 1 | Frame finished; swap banks |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 line map, 1 tables, 2 control |
| cfg_addr | input | CFG_AW | Configuration address |
| cfg_wdata | input | PIX_W | Configuration data |
| rd_region | input | 2 | Histogram to read |
| rd_bin | input | PIX_W | Bin to read |
| rd_count | output | CNT_W | Count from the finished bank |
| frame_done | output | 1 | Counts of the finished frame are readable |
| out_valid | output | 1 | Remapped pixel valid |
| out_data | output | PIX_W | Remapped, depth-reduced pixel |

## Verification
Two events can land in the same cycle: the last pixel of a frame and the `frame_end` strobe. A correct design must count that pixel into the frame that is closing, not into the next one. The bench runs some frames with the strobe on the final pixel and others with the strobe one idle cycle later. After each swap it compares every bin of all four regions with its own model. A pixel counted into the wrong bank shows up as one bin off by one. A second overlap is the clearing first pixel of a frame, which must both wipe the bank and count itself. The bench checks this in the bin reads after the following swap.

// File: rtl/vid_region_hist.sv
module vid_region_hist #(
  parameter int PIX_W   = 8,
  parameter int CNT_W   = 20,
  parameter int LINES   = 1024,
  parameter int REGIONS = 4,
  parameter int CFG_AW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              pix_sol,
  input  logic              pix_sof,
  input  logic              frame_end,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [PIX_W-1:0]  cfg_wdata,
  input  logic [1:0]        rd_region,
  input  logic [PIX_W-1:0]  rd_bin,
  output logic [CNT_W-1:0]  rd_count,
  output logic              frame_done,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_data
);
  localparam int BINS = 1 << PIX_W;
  localparam int LW   = $clog2(LINES);
  localparam int RW   = $clog2(REGIONS);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [RW-1:0]    rmap  [LINES];
  logic [PIX_W-1:0] lut   [REGIONS][BINS];
  logic [1:0]       depth [REGIONS];
  logic [RW-1:0]    lsel  [REGIONS];
  logic             clr_en;
  logic             bank;
  logic [LW-1:0]    line_q;
  logic [CNT_W-1:0] hist  [2][REGIONS][BINS];

  wire [LW-1:0]    line_c = pix_sof ? '0 : (pix_sol ? LW'(line_q + 1'b1) : line_q);
  wire [RW-1:0]    region = rmap[line_c];
  wire [PIX_W-1:0] mapped = lut[lsel[region]][pix_data];
  wire [1:0]       dcode  = depth[region];
  wire [PIX_W-1:0] mask   = (dcode == 2'd0) ? '1 : (dcode == 2'd1) ? ~PIX_W'(1) : ~PIX_W'(3);

  assign rd_count = hist[!bank][rd_region[RW-1:0]][rd_bin];

  always_ff @(posedge clk) begin
    if (cfg_we && cfg_sel == 2'd0) rmap[cfg_addr[LW-1:0]] <= cfg_wdata[RW-1:0];
    if (cfg_we && cfg_sel == 2'd1) lut[cfg_addr[PIX_W+RW-1:PIX_W]][cfg_addr[PIX_W-1:0]] <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_en <= 1'b1;
      for (int r = 0; r < REGIONS; r++) begin
        depth[r] <= 2'd0;
        lsel[r]  <= '0;
      end
    end else if (cfg_we && cfg_sel == 2'd2) begin
      if (cfg_addr[1:0] == 2'd0) clr_en <= cfg_wdata[0];
      for (int r = 0; r < REGIONS; r++) begin
        if (cfg_addr[1:0] == 2'd1) depth[r] <= cfg_wdata[2*r +: 2];
        if (cfg_addr[1:0] == 2'd2) lsel[r]  <= cfg_wdata[RW*r +: RW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++)
        for (int r = 0; r < REGIONS; r++)
          for (int b = 0; b < BINS; b++) hist[k][r][b] <= '0;
      bank       <= 1'b0;
      line_q     <= '0;
      frame_done <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
    end else begin
      if (pix_valid) begin
        line_q <= line_c;
        if (pix_sof && clr_en) begin
          for (int r = 0; r < REGIONS; r++)
            for (int b = 0; b < BINS; b++) hist[bank][r][b] <= '0;
          hist[bank][region][pix_data] <= CNT_W'(1);
        end else if (hist[bank][region][pix_data] != CMAX) begin
          hist[bank][region][pix_data] <= hist[bank][region][pix_data] + 1'b1;
        end
        out_data <= mapped & mask;
      end
      out_valid  <= pix_valid;
      frame_done <= frame_end;
      if (frame_end) bank <= ~bank;
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> frame_done);
  assert_done_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> !frame_done);
  assert_out_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  assert_out_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
  assert_depth6_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && dcode[1]) |=> out_data[1:0] == 2'b00);
  assert_depth7_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && dcode == 2'd1) |=> out_data[0] == 1'b0);
  assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!frame_end) && $stable(rd_region) && $stable(rd_bin)) |-> $stable(rd_count));
endmodule

// File: tb/sim_vid_region_hist.sv
`timescale 1ns/1ps
module sim_vid_region_hist;
  localparam int CW = 12;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic pix_valid = 0, pix_sol = 0, pix_sof = 0, frame_end = 0;
  logic [7:0] pix_data = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [9:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic [1:0] rd_region = 0;
  logic [7:0] rd_bin = 0;
  logic [CW-1:0] rd_count;
  logic frame_done, out_valid;
  logic [7:0] out_data;

  vid_region_hist #(.CNT_W(CW)) u0 (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  int unsigned mh [2][4][256];
  logic [1:0] mmap [1024];
  logic [7:0] mlut [4][256];
  logic [1:0] mdepth [4];
  logic [1:0] msel [4];
  bit mclr, mact;
  int mline;
  bit ev, ed;
  logic [7:0] eo;

  function automatic logic [7:0] f_mask(logic [7:0] v, logic [1:0] d);
    if (d == 0) return v;
    if (d == 1) return v & 8'hFE;
    return v & 8'hFC;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mh[k, r, b]) mh[k][r][b] = 0;
      mclr = 1; mact = 0; mline = 0; ev = 0; ed = 0; eo = 0;
      for (int r = 0; r < 4; r++) begin mdepth[r] = 0; msel[r] = 0; end
    end else begin
      ev = pix_valid;
      ed = frame_end;
      if (pix_valid) begin
        int ln, rg;
        ln = pix_sof ? 0 : (pix_sol ? (mline + 1) % 1024 : mline);
        mline = ln;
        rg = mmap[ln];
        if (pix_sof && mclr) begin
          for (int r = 0; r < 4; r++) for (int b = 0; b < 256; b++) mh[mact][r][b] = 0;
        end
        if (mh[mact][rg][pix_data] < CMAX) mh[mact][rg][pix_data]++;
        eo = f_mask(mlut[msel[rg]][pix_data], mdepth[rg]);
      end
      if (frame_end) mact = !mact;
      if (cfg_we) begin
        if (cfg_sel == 0) mmap[cfg_addr] = cfg_wdata[1:0];
        if (cfg_sel == 1) mlut[cfg_addr[9:8]][cfg_addr[7:0]] = cfg_wdata;
        if (cfg_sel == 2 && cfg_addr[1:0] == 0) mclr = cfg_wdata[0];
        if (cfg_sel == 2 && cfg_addr[1:0] == 1) for (int r = 0; r < 4; r++) mdepth[r] = cfg_wdata[2*r +: 2];
        if (cfg_sel == 2 && cfg_addr[1:0] == 2) for (int r = 0; r < 4; r++) msel[r] = cfg_wdata[2*r +: 2];
      end
    end
  end

  // R6 R8 R9: cycle-by-cycle output checks
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (out_valid !== ev) begin
        fails++; $display("FAIL R8 out_valid actual=%0d expected=%0d", out_valid, ev);
      end
      if (ev) begin
        checks++;
        if (out_data !== eo) begin
          fails++; $display("FAIL R8/R9 out_data actual=%0h expected=%0h", out_data, eo);
        end
      end
      checks++;
      if (frame_done !== ed) begin
        fails++; $display("FAIL R6 frame_done actual=%0d expected=%0d", frame_done, ed);
      end
    end
  end

  task automatic cfg(input logic [1:0] s, input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic px(input logic [7:0] d, input bit sol, input bit sof, input bit fe);
    @(negedge clk);
    pix_valid = 1; pix_data = d; pix_sol = sol; pix_sof = sof; frame_end = fe;
  endtask

  task automatic idle(input bit fe);
    @(negedge clk);
    pix_valid = 0; pix_sol = 0; pix_sof = 0; frame_end = fe;
  endtask

  task automatic read_chk(input int r, input int b, input string tag);
    int exp;
    #0.5; rd_region = r[1:0]; rd_bin = b[7:0];
    #0.2; exp = mh[!mact][r][b];
    checks++;
    if (rd_count !== CW'(exp)) begin
      fails++;
      $display("FAIL %s region %0d bin %0d actual=%0d expected=%0d", tag, r, b, rd_count, exp);
    end
  endtask

  task automatic read_all(input string tag);
    idle(0);
    for (int r = 0; r < 4; r++) for (int b = 0; b < 256; b++) read_chk(r, b, tag);
  endtask

  // mode: 0 full range, 1 narrow, 2 constant
  task automatic frame(input int nl, input int np, input int gap, input int mode, input bit fe_last);
    for (int l = 0; l < nl; l++) begin
      for (int p = 0; p < np; p++) begin
        logic [7:0] d;
        if ($urandom_range(99) < gap) idle(0);
        d = (mode == 0) ? 8'($urandom_range(255)) :
            (mode == 1) ? 8'(8'h70 + $urandom_range(15)) : 8'h33;
        px(d, p == 0, (l == 0 && p == 0), fe_last && l == nl - 1 && p == np - 1);
        if (p == np / 2 && l == 1) begin
          read_chk($urandom_range(3), $urandom_range(255), "R5 mid-frame");
          read_chk(0, 8'h33, "R5 mid-frame");
        end
      end
    end
    if (!fe_last) begin idle(0); idle(1); end
    idle(0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || frame_done !== 0) begin
      fails++; $display("FAIL R1 reset outputs actual=%0d%0d expected=00", out_valid, frame_done);
    end
    for (int r = 0; r < 4; r++) for (int b = 0; b < 256; b += 17) read_chk(r, b, "R1 reset count");

    for (int l = 0; l < 1024; l++) cfg(0, 10'(l), 8'($urandom_range(3)));
    for (int a = 0; a < 1024; a++) cfg(1, 10'(a), 8'($urandom_range(255)));
    cfg(2, 1, 8'b11_10_01_00);   // R9 depth codes per region
    cfg(2, 2, 8'b00_01_10_11);   // R8 table selection per region

    frame(8, 40, 20, 0, 0);  read_all("R2 R3 frame1");
    frame(12, 30, 0, 1, 1);  read_all("R2 R6 fe-on-last");
    frame(6, 50, 35, 2, 1);  read_all("R2 R7 clear");

    // R3: directed band map, lines 0-2 region 2, lines 3-5 region 1
    for (int l = 0; l < 6; l++) cfg(0, 10'(l), (l < 3) ? 8'd2 : 8'd1);
    frame(6, 20, 10, 0, 0); read_all("R3 band map");

    // R10: reprogram depth and tables between frames
    cfg(2, 1, 8'b00_00_00_00);
    cfg(2, 2, 8'b11_10_01_00);
    frame(4, 25, 0, 0, 1); read_all("R10 reconfig");

    // R7: clear disabled, two frames accumulate onto old contents
    cfg(2, 0, 8'd0);
    frame(5, 30, 10, 1, 0); read_all("R7 no-clear a");
    frame(5, 30, 10, 1, 1); read_all("R7 no-clear b");
    cfg(2, 0, 8'd1);

    // R4: saturation with one long line of a constant value
    frame(1, CMAX + 100, 0, 2, 0);
    read_all("R4 saturate");
    read_chk(mmap[0], 8'h33, "R4 saturate bin");

    idle(0); idle(0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #600000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule